// File: doc/BRIEF.md
# Branch-Aware Program Counter

This block holds the program counter of a simple 32-bit instruction pipeline and works out the address of the next instruction. Each cycle it receives the current instruction word and the two register operands named by that instruction's source fields. From these it decides whether a compare-and-branch instruction redirects the flow, and on a step it loads either the sequential address or the branch target.

Branch offsets are counted in instructions, not bytes. The signed 16-bit offset field is scaled by four and added to the address that follows the branch, not to the branch's own address. Every other instruction moves on to the next word. The step enable is a plain control pin. When it is low the counter holds its value, so the surrounding pipeline stalls the block simply by not stepping it. There is no handshake and no back-pressure path.

Top module: `brnpc_unit`

## Requirements
- R1: A synchronous reset, sampled on the rising edge, sets the PC to 0x00000000.
- R2: When the step enable is low, the PC keeps its value, whatever the instruction and operands are.
- R3: On a step with an instruction whose opcode (bits 31:26) is neither 4 nor 5, the PC becomes PC+4.
- R4: Opcode 4 is branch-on-equal. When the two operands are equal, a step loads PC + 4 + sign-extended(bits 15:0) × 4.
- R5: A branch-on-equal whose operands differ is not taken, and a step loads PC+4.
- R6: Opcode 5 is branch-on-not-equal. It is taken, loading the same target as R4, when the operands differ. When they are equal a step loads PC+4.
- R7: The offset field is two's complement, so a negative field moves the PC backwards. The field values 0x8000 and 0x7FFF reach −32768 and +32767 instructions from PC+4.
- R8: All address sums wrap modulo 2^32.
- R9: `br_taken` is combinational from the present inputs. It is high only when the opcode is 4 or 5 and that branch's condition holds.
- R10: The two low bits of the PC are always 00.
- R11: The word 0x11200003 (opcode 4, rs=9, rt=0, offset 3) with equal operands moves the PC to the fourth instruction after the branch, which is the branch address + 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Load the next address on this edge |
| instr | input | 32 | Current instruction word |
| rs_val | input | XLEN | Value of the register named by bits 25:21 |
| rt_val | input | XLEN | Value of the register named by bits 20:16 |
| pc_q | output | PC_W | Current program counter |
| br_taken | output | 1 | The present instruction is a branch whose condition holds |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, 32-bit operands and a reset address of zero. With this full 32-bit address space, two branches alone reach the extremes. A taken branch with offset field 0x8000 from address 0 lands at 0xFFFE0004. A following branch with 0x7FFF wraps the counter back to 0x00000004. This exercises both ends of the offset range and the modulo-2^32 wrap. Operand width 32 lets the tests use equal and unequal values that differ only in the top bit.

// File: rtl/brnpc_pkg.sv
package brnpc_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_HI  = 31;
  localparam int OPC_LO  = 26;
  localparam int OPC_W   = OPC_HI - OPC_LO + 1;
  localparam int IMM_W   = 16;
  localparam int WORD_SH = 2;

  localparam logic [OPC_W-1:0] OPC_BR_EQ = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BR_NE = 6'd5;

  typedef enum logic [1:0] {
    BRK_NONE = 2'd0,
    BRK_EQ   = 2'd1,
    BRK_NE   = 2'd2
  } br_kind_e;
endpackage

// File: rtl/brnpc_decode.sv
module brnpc_decode
  import brnpc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output br_kind_e           kind,
  output logic [PC_W-1:0]    offs_bytes
);
  localparam int EXT_W = PC_W - IMM_W - WORD_SH;

  logic [OPC_W-1:0] opc;
  logic [IMM_W-1:0] imm;

  assign opc = instr[OPC_HI:OPC_LO];
  assign imm = instr[IMM_W-1:0];

  always_comb begin
    unique case (opc)
      OPC_BR_EQ: kind = BRK_EQ;
      OPC_BR_NE: kind = BRK_NE;
      default:   kind = BRK_NONE;
    endcase
  end

  // word count -> byte offset, sign preserved
  assign offs_bytes = {{EXT_W{imm[IMM_W-1]}}, imm, {WORD_SH{1'b0}}};
endmodule

// File: rtl/brnpc_cond.sv
module brnpc_cond
  import brnpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_kind_e          kind,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  output logic              taken
);
  logic same;
  assign same = (op_a == op_b);

  always_comb begin
    unique case (kind)
      BRK_EQ:  taken = same;
      BRK_NE:  taken = !same;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/brnpc_target.sv
module brnpc_target
  import brnpc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0] pc_cur,
  input  logic [PC_W-1:0] offs_bytes,
  input  logic            taken,
  output logic [PC_W-1:0] pc_next
);
  localparam logic [PC_W-1:0] STRIDE = PC_W'(1 << WORD_SH);

  logic [PC_W-1:0] seq_addr;
  logic [PC_W-1:0] tgt_addr;

  assign seq_addr = pc_cur + STRIDE;
  assign tgt_addr = seq_addr + offs_bytes;
  assign pc_next  = taken ? tgt_addr : seq_addr;
endmodule

// File: rtl/brnpc_unit.sv
module brnpc_unit
  import brnpc_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              XLEN     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_en,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [XLEN-1:0]     rs_val,
  input  logic [XLEN-1:0]     rt_val,
  output logic [PC_W-1:0]     pc_q,
  output logic                br_taken
);
  br_kind_e        kind;
  logic [PC_W-1:0] offs_bytes;
  logic [PC_W-1:0] pc_next;

  brnpc_decode #(.PC_W(PC_W)) u_dec (
    .instr      (instr),
    .kind       (kind),
    .offs_bytes (offs_bytes)
  );

  brnpc_cond #(.XLEN(XLEN)) u_cond (
    .kind  (kind),
    .op_a  (rs_val),
    .op_b  (rt_val),
    .taken (br_taken)
  );

  brnpc_target #(.PC_W(PC_W)) u_tgt (
    .pc_cur     (pc_q),
    .offs_bytes (offs_bytes),
    .taken      (br_taken),
    .pc_next    (pc_next)
  );

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= RESET_PC;
    else if (step_en) pc_q <= pc_next;
  end
endmodule

// File: rtl/brnpc_unit_chk.sv
module brnpc_unit_chk
  import brnpc_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              XLEN     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input logic               clk,
  input logic               rst,
  input logic               step_en,
  input logic [INSTR_W-1:0] instr,
  input logic [XLEN-1:0]    rs_val,
  input logic [XLEN-1:0]    rt_val,
  input logic [PC_W-1:0]    pc_q,
  input logic               br_taken
);
  logic seen_rst;
  logic rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) seen_rst <= 1'b1;
    else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
  end

  logic [OPC_W-1:0] opc;
  assign opc = instr[OPC_HI:OPC_LO];

  AST_RESET_VALUE: assert property (@(posedge clk) disable iff (rst)
    (seen_rst === 1'b1 && rst_d) |-> pc_q == RESET_PC); // R1
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    (!rst_d && !$past(step_en)) |-> pc_q == $past(pc_q)); // R2
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    (!rst_d && $past(step_en) && !$past(br_taken)) |-> pc_q == $past(pc_q) + PC_W'(4)); // R3
  AST_EQ_TAKES: assert property (@(posedge clk) disable iff (rst)
    (opc == OPC_BR_EQ && rs_val == rt_val) |-> br_taken); // R4
  AST_NE_TAKES: assert property (@(posedge clk) disable iff (rst)
    (opc == OPC_BR_NE && rs_val != rt_val) |-> br_taken); // R6
  AST_TAKEN_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (opc == OPC_BR_EQ || opc == OPC_BR_NE)); // R9
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    pc_q[1:0] == 2'b00); // R10
endmodule

bind brnpc_unit brnpc_unit_chk #(.PC_W(PC_W), .XLEN(XLEN), .RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst(rst), .step_en(step_en), .instr(instr),
  .rs_val(rs_val), .rt_val(rt_val), .pc_q(pc_q), .br_taken(br_taken)
);

// File: tb/brnpc_unit_test.sv
module brnpc_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] pc_q;
  logic        br_taken;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [31:0] pc_model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brnpc_unit uut (
    .clk(clk), .rst(rst), .step_en(step_en), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .pc_q(pc_q), .br_taken(br_taken)
  );

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Apply one instruction at the falling edge, check taken, clock it, check the PC.
  task automatic apply(input string req, input logic [31:0] iw, input logic [31:0] a,
                       input logic [31:0] b, input logic en, input logic exp_tk,
                       input logic [31:0] exp_pc);
    @(negedge clk);
    instr = iw; rs_val = a; rt_val = b; step_en = en;
    #1;
    check({req, " taken"}, {31'd0, br_taken}, {31'd0, exp_tk});
    @(posedge clk);
    @(negedge clk);
    step_en = 1'b0;
    check({req, " pc"}, pc_q, exp_pc);
    check("R10 align", {30'd0, pc_q[1:0]}, 32'd0);
    pc_model = exp_pc;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1; step_en = 1'b1; instr = enc(6'd0, 0, 0, 16'd0);
    @(posedge clk); @(negedge clk);
    rst = 1'b0; step_en = 1'b0;
    check("R1 reset pc", pc_q, 32'h0);
    pc_model = 32'h0;
  endtask

  task automatic t_sequential();
    apply("R3 op0", enc(6'd0, 5'd1, 5'd2, 16'hFFFF), 32'd5, 32'd5, 1'b1, 1'b0, pc_model + 4);
    apply("R3 op8", enc(6'd8, 5'd3, 5'd3, 16'h0010), 32'd1, 32'd1, 1'b1, 1'b0, pc_model + 4);
    apply("R9 op6", enc(6'd6, 5'd3, 5'd3, 16'h0004), 32'd0, 32'd7, 1'b1, 1'b0, pc_model + 4);
  endtask

  task automatic t_beq();
    logic [31:0] start;
    start = pc_model;
    apply("R11 example", 32'h11200003, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, start + 32'd16);
    apply("R4 beq fwd", enc(6'd4, 5'd2, 5'd3, 16'd10), 32'd42, 32'd42, 1'b1, 1'b1,
          pc_model + 4 + 32'd40);
    apply("R5 beq differ", enc(6'd4, 5'd2, 5'd3, 16'd10), 32'h8000_0000, 32'h0, 1'b1, 1'b0,
          pc_model + 4);
  endtask

  task automatic t_bne();
    apply("R6 bne differ", enc(6'd5, 5'd4, 5'd5, 16'd2), 32'd1, 32'd2, 1'b1, 1'b1,
          pc_model + 4 + 32'd8);
    apply("R6 bne equal", enc(6'd5, 5'd4, 5'd5, 16'd2), 32'd9, 32'd9, 1'b1, 1'b0,
          pc_model + 4);
  endtask

  task automatic t_negative();
    apply("R7 back two", enc(6'd4, 5'd1, 5'd1, 16'hFFFE), 32'd3, 32'd3, 1'b1, 1'b1,
          pc_model - 4);
    apply("R7 self loop", enc(6'd5, 5'd1, 5'd2, 16'hFFFF), 32'd3, 32'd4, 1'b1, 1'b1,
          pc_model);
  endtask

  task automatic t_hold();
    logic [31:0] keep;
    keep = pc_model;
    apply("R2 hold beq", enc(6'd4, 5'd1, 5'd1, 16'd100), 32'd0, 32'd0, 1'b0, 1'b1, keep);
    apply("R2 hold seq", enc(6'd0, 5'd0, 5'd0, 16'd0), 32'd0, 32'd1, 1'b0, 1'b0, keep);
  endtask

  task automatic t_wrap();
    t_reset();
    apply("R7 min offset", enc(6'd4, 5'd0, 5'd0, 16'h8000), 32'd0, 32'd0, 1'b1, 1'b1,
          32'hFFFE_0004);
    apply("R8 wrap max", enc(6'd4, 5'd0, 5'd0, 16'h7FFF), 32'd0, 32'd0, 1'b1, 1'b1,
          32'h0000_0004);
    apply("R8 wrap back", enc(6'd5, 5'd0, 5'd1, 16'hFFFD), 32'd0, 32'd1, 1'b1, 1'b1,
          32'hFFFF_FFFC);
    apply("R8 seq wrap", enc(6'd0, 5'd0, 5'd0, 16'd0), 32'd0, 32'd0, 1'b1, 1'b0,
          32'h0000_0000);
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_beq();
    t_bne();
    t_negative();
    t_hold();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule